// File: doc/BRIEF.md
# Operate Microinstruction Execution Unit

This block carries out the register-only instruction class of a 12-bit accumulator machine. That class is opcode 7 in the top three instruction bits. One instruction word can ask for several small actions at once. These include clearing and complementing the accumulator and the one-bit link, incrementing the 13-bit link:accumulator pair, shifting, testing for a skip, OR-ing in the front-panel switches, and stopping the machine. The unit carries out these actions in a fixed order of events. It returns the new accumulator and link, along with three one-cycle flags: a skip request for the program-counter logic, a halt request and a user-mode trap request.

Each transaction is offered with `in_valid`. The unit is a two-stage pipeline that accepts one word per cycle. Stage one applies the clears and complements and evaluates the skip tests. Stage two applies the increment and the shift, or the switch-OR and halt/trap handling. The results appear with `out_valid` two clock edges after the input was taken. The unit does not move the program counter. It only reports that the next word must be passed over. Instructions of other opcodes, and the arithmetic-extension encoding, go through untouched with no flags raised.

Top module: `opr_exec`

## Requirements
- R1: A word sampled with `in_valid` high at one rising edge produces `out_valid` high after the next rising edge. In cycles with `out_valid` low, `skip`, `halt_req` and `trap_req` are low. Reset clears `out_valid`, `ac_out`, `link_out` and all flags.
- R2: Register group (instr[11:9]=7, instr[8]=0). Bit 7 clears AC, bit 6 clears the link, bit 5 inverts AC and bit 4 inverts the link. A clear applies before the matching invert, so clear-plus-invert yields all ones. All of these precede the increment and the shift.
- R3: In the register group, bit 0 adds one to the 13-bit {link, AC} value, with the link as the most significant bit. Incrementing all ones wraps both the link and AC to zero.
- R4: In the register group, bits 3:1 choose a shift, applied after the increment: 001 exchanges the upper and lower 6-bit halves of AC with the link untouched; 010 rotates {link, AC} left one place and 011 left two places; 100 rotates right one place and 101 right two places. Codes 000, 110 and 111 do no shift.
- R5: A register-group word never raises `skip`, `halt_req` or `trap_req`.
- R6: Test group (instr[8]=1, instr[0]=0). Bit 6 tests AC[11]=1, bit 5 tests AC=0 and bit 4 tests link=1, all on the incoming values. The chosen tests are ORed together. `skip` is high when that OR differs from bit 3, so bit 3 with no tests chosen always skips.
- R7: In the test group, bit 7 clears AC, and then bit 2 ORs `switches` into AC. The link leaves unchanged.
- R8: In the test group, outside user mode, bit 1 raises `halt_req`.
- R9: In the test group with `user_mode` high, bits 2 and 1 neither change AC nor raise `halt_req`. Either of them raises `trap_req` instead. The clear and the skip still act.
- R10: A word with instr[11:9]=7, instr[8]=1 and instr[0]=1 passes AC and the link through unchanged and raises no flag.
- R11: A word whose instr[11:9] is not 7 passes AC and the link through unchanged and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Transaction present on the inputs |
| instr | input | 12 | Instruction word |
| ac_in | input | DATA_W | Accumulator before the instruction |
| link_in | input | 1 | Link before the instruction |
| switches | input | DATA_W | Front-panel switch register |
| user_mode | input | 1 | Restricted mode: switch-OR and halt trap instead |
| out_valid | output | 1 | Result present on the outputs |
| ac_out | output | DATA_W | Accumulator after the instruction |
| link_out | output | 1 | Link after the instruction |
| skip | output | 1 | Next instruction is to be passed over |
| halt_req | output | 1 | Halt the processor |
| trap_req | output | 1 | Restricted function attempted in user mode |

## Verification
The bench targets the ordering corners. Clear followed by invert must give all ones, not zero. Clear followed by increment must give one. An increment of all ones must wrap the link too, or a carry-blind adder shows up as a stuck link. Each shift code is tried with the link set, so a rotate that skips the link, or a byte swap that disturbs it, shows up. The reserved shift codes 110 and 111 are included. On the test side, a zero-test combined with a clear on a nonzero AC catches a design that tests after clearing. The sense bit with no tests selected catches a skip that never fires. User-mode words carrying the switch-OR or halt bits catch a design that still changes AC or halts rather than trapping.

// File: rtl/opr_pkg.sv
package opr_pkg;

  localparam int INSTR_W  = 12;
  localparam int OPC_HI   = 11;
  localparam int OPC_LO   = 9;
  localparam logic [2:0] OPC_OPERATE = 3'b111;
  localparam int SEL_BIT  = 8;   // 0: register group, 1: test/extension
  localparam int EXT_BIT  = 0;   // in test/extension half: 1 selects extension

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_REG   = 2'd1,
    GRP_TEST  = 2'd2,
    GRP_EXT   = 2'd3
  } opr_grp_e;

  typedef enum logic [2:0] {
    SH_NONE = 3'd0,
    SH_SWAP = 3'd1,
    SH_L1   = 3'd2,
    SH_L2   = 3'd3,
    SH_R1   = 3'd4,
    SH_R2   = 3'd5,
    SH_RSV6 = 3'd6,
    SH_RSV7 = 3'd7
  } opr_shift_e;

  // controls consumed by the first event step
  typedef struct packed {
    opr_grp_e grp;
    logic     clr_ac;
    logic     clr_lk;
    logic     inv_ac;
    logic     inv_lk;
    logic     t_neg;
    logic     t_zero;
    logic     t_link;
    logic     t_sense;
  } opr_front_t;

  // controls consumed by the second event step
  typedef struct packed {
    opr_grp_e   grp;
    logic       inc;
    opr_shift_e shf;
    logic       or_sw;
    logic       stop;
  } opr_back_t;

endpackage

// File: rtl/opr_rst_sync.sv
module opr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output opr_front_t         fctl,
  output opr_back_t          bctl
);

  opr_grp_e grp;

  always_comb begin
    if (instr[OPC_HI:OPC_LO] != OPC_OPERATE) begin
      grp = GRP_NONE;
    end else if (!instr[SEL_BIT]) begin
      grp = GRP_REG;
    end else if (!instr[EXT_BIT]) begin
      grp = GRP_TEST;
    end else begin
      grp = GRP_EXT;
    end
  end

  always_comb begin
    fctl     = '0;
    bctl     = '0;
    fctl.grp = grp;
    bctl.grp = grp;
    case (grp)
      GRP_REG: begin
        fctl.clr_ac = instr[7];
        fctl.clr_lk = instr[6];
        fctl.inv_ac = instr[5];
        fctl.inv_lk = instr[4];
        bctl.inc    = instr[0];
        bctl.shf    = opr_shift_e'(instr[3:1]);
      end
      GRP_TEST: begin
        fctl.clr_ac  = instr[7];
        fctl.t_neg   = instr[6];
        fctl.t_zero  = instr[5];
        fctl.t_link  = instr[4];
        fctl.t_sense = instr[3];
        bctl.or_sw   = instr[2];
        bctl.stop    = instr[1];
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/opr_front.sv
module opr_front
  import opr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  opr_front_t        fctl,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              link_o,
  output logic              skip_o
);

  localparam int SIGN = DATA_W - 1;

  logic cond;

  // tests look at the incoming accumulator and link
  always_comb begin
    cond = (fctl.t_neg  && ac_i[SIGN])
         || (fctl.t_zero && (ac_i == '0))
         || (fctl.t_link && link_i);
  end

  always_comb begin
    ac_o   = ac_i;
    link_o = link_i;
    skip_o = 1'b0;
    case (fctl.grp)
      GRP_REG: begin
        if (fctl.clr_ac) ac_o   = '0;
        if (fctl.clr_lk) link_o = 1'b0;
        if (fctl.inv_ac) ac_o   = ~ac_o;
        if (fctl.inv_lk) link_o = ~link_o;
      end
      GRP_TEST: begin
        skip_o = cond ^ fctl.t_sense;
        if (fctl.clr_ac) ac_o = '0;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/opr_back.sv
module opr_back
  import opr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  opr_back_t         bctl,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              link_i,
  input  logic              skip_i,
  input  logic [DATA_W-1:0] sw_i,
  input  logic              user_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              link_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              trap_o
);

  localparam int LW   = DATA_W + 1;
  localparam int HALF = DATA_W / 2;

  logic [LW-1:0] lv_inc;
  logic [LW-1:0] lv_shf;

  // increment of the combined link:accumulator, carry out discarded
  always_comb begin
    lv_inc = {link_i, ac_i};
    if (bctl.inc) lv_inc = lv_inc + LW'(1);
  end

  always_comb begin
    case (bctl.shf)
      SH_SWAP: lv_shf = {lv_inc[DATA_W], lv_inc[HALF-1:0], lv_inc[DATA_W-1:HALF]};
      SH_L1:   lv_shf = {lv_inc[LW-2:0], lv_inc[LW-1]};
      SH_L2:   lv_shf = {lv_inc[LW-3:0], lv_inc[LW-1:LW-2]};
      SH_R1:   lv_shf = {lv_inc[0], lv_inc[LW-1:1]};
      SH_R2:   lv_shf = {lv_inc[1:0], lv_inc[LW-1:2]};
      default: lv_shf = lv_inc;
    endcase
  end

  always_comb begin
    ac_o   = ac_i;
    link_o = link_i;
    skip_o = 1'b0;
    halt_o = 1'b0;
    trap_o = 1'b0;
    case (bctl.grp)
      GRP_REG: begin
        {link_o, ac_o} = lv_shf;
      end
      GRP_TEST: begin
        skip_o = skip_i;
        if (user_i) begin
          trap_o = bctl.or_sw | bctl.stop;
        end else begin
          if (bctl.or_sw) ac_o = ac_i | sw_i;
          halt_o = bctl.stop;
        end
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/opr_exec.sv
module opr_exec
  import opr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [11:0]       instr,
  input  logic [DATA_W-1:0] ac_in,
  input  logic              link_in,
  input  logic [DATA_W-1:0] switches,
  input  logic              user_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] ac_out,
  output logic              link_out,
  output logic              skip,
  output logic              halt_req,
  output logic              trap_req
);

  logic rst_core_n;

  opr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // ---------------- event step one ----------------
  opr_front_t dec_f;
  opr_back_t  dec_b;

  opr_decode u_dec (
    .instr (instr),
    .fctl  (dec_f),
    .bctl  (dec_b)
  );

  logic [DATA_W-1:0] fr_ac;
  logic              fr_link;
  logic              fr_skip;

  opr_front #(.DATA_W(DATA_W)) u_front (
    .fctl   (dec_f),
    .ac_i   (ac_in),
    .link_i (link_in),
    .ac_o   (fr_ac),
    .link_o (fr_link),
    .skip_o (fr_skip)
  );

  // stage one registers
  logic              s1_vld_q,  s1_vld_d;
  opr_back_t         s1_ctl_q,  s1_ctl_d;
  logic [DATA_W-1:0] s1_ac_q,   s1_ac_d;
  logic              s1_lk_q,   s1_lk_d;
  logic              s1_sk_q,   s1_sk_d;
  logic [DATA_W-1:0] s1_sw_q,   s1_sw_d;
  logic              s1_usr_q,  s1_usr_d;
  logic              s1_en;

  always_comb begin
    s1_en    = in_valid;
    s1_vld_d = in_valid;
    s1_ctl_d = s1_ctl_q;
    s1_ac_d  = s1_ac_q;
    s1_lk_d  = s1_lk_q;
    s1_sk_d  = s1_sk_q;
    s1_sw_d  = s1_sw_q;
    s1_usr_d = s1_usr_q;
    if (s1_en) begin
      s1_ctl_d = dec_b;
      s1_ac_d  = fr_ac;
      s1_lk_d  = fr_link;
      s1_sk_d  = fr_skip;
      s1_sw_d  = switches;
      s1_usr_d = user_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s1_vld_q <= 1'b0;
      s1_ctl_q <= '0;
      s1_ac_q  <= '0;
      s1_lk_q  <= 1'b0;
      s1_sk_q  <= 1'b0;
      s1_sw_q  <= '0;
      s1_usr_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_ctl_q <= s1_ctl_d;
      s1_ac_q  <= s1_ac_d;
      s1_lk_q  <= s1_lk_d;
      s1_sk_q  <= s1_sk_d;
      s1_sw_q  <= s1_sw_d;
      s1_usr_q <= s1_usr_d;
    end
  end

  // ---------------- event step two ----------------
  logic [DATA_W-1:0] bk_ac;
  logic              bk_link;
  logic              bk_skip;
  logic              bk_halt;
  logic              bk_trap;

  opr_back #(.DATA_W(DATA_W)) u_back (
    .bctl   (s1_ctl_q),
    .ac_i   (s1_ac_q),
    .link_i (s1_lk_q),
    .skip_i (s1_sk_q),
    .sw_i   (s1_sw_q),
    .user_i (s1_usr_q),
    .ac_o   (bk_ac),
    .link_o (bk_link),
    .skip_o (bk_skip),
    .halt_o (bk_halt),
    .trap_o (bk_trap)
  );

  // output registers
  logic              o_vld_q,  o_vld_d;
  logic [DATA_W-1:0] o_ac_q,   o_ac_d;
  logic              o_lk_q,   o_lk_d;
  logic              o_sk_q,   o_sk_d;
  logic              o_hlt_q,  o_hlt_d;
  logic              o_trp_q,  o_trp_d;
  logic              o_en;

  always_comb begin
    o_en    = s1_vld_q;
    o_vld_d = s1_vld_q;
    o_ac_d  = o_ac_q;
    o_lk_d  = o_lk_q;
    o_sk_d  = 1'b0;
    o_hlt_d = 1'b0;
    o_trp_d = 1'b0;
    if (o_en) begin
      o_ac_d  = bk_ac;
      o_lk_d  = bk_link;
      o_sk_d  = bk_skip;
      o_hlt_d = bk_halt;
      o_trp_d = bk_trap;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      o_vld_q <= 1'b0;
      o_ac_q  <= '0;
      o_lk_q  <= 1'b0;
      o_sk_q  <= 1'b0;
      o_hlt_q <= 1'b0;
      o_trp_q <= 1'b0;
    end else begin
      o_vld_q <= o_vld_d;
      o_ac_q  <= o_ac_d;
      o_lk_q  <= o_lk_d;
      o_sk_q  <= o_sk_d;
      o_hlt_q <= o_hlt_d;
      o_trp_q <= o_trp_d;
    end
  end

  assign out_valid = o_vld_q;
  assign ac_out    = o_ac_q;
  assign link_out  = o_lk_q;
  assign skip      = o_sk_q;
  assign halt_req  = o_hlt_q;
  assign trap_req  = o_trp_q;

endmodule

// File: rtl/opr_exec_chk.sv
module opr_exec_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [11:0]       instr,
  input logic [DATA_W-1:0] ac_in,
  input logic              link_in,
  input logic              user_mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] ac_out,
  input logic              link_out,
  input logic              skip,
  input logic              halt_req,
  input logic              trap_req
);

  // cycles since reset release, saturating; covers synchronizer and pipeline
  logic [2:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= 3'd0;
    end else if (warm_q != 3'd7) begin
      warm_q <= warm_q + 3'd1;
    end
  end
  logic warm;
  assign warm = (warm_q >= 3'd5);

  logic is_opr, is_reg, is_test, is_ext;
  assign is_opr  = (instr[11:9] == 3'b111);
  assign is_reg  = is_opr && !instr[8];
  assign is_test = is_opr && instr[8] && !instr[0];
  assign is_ext  = is_opr && instr[8] && instr[0];
  logic chk_unused;
  assign chk_unused = ^instr[6:3];

  // R1: two-edge latency
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 2)));

  // R1: flags only with a result
  p_flags_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (skip || halt_req || trap_req) |-> out_valid);

  // R5: register group raises no flag
  p_reg_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(is_reg, 2)) |-> (!skip && !halt_req && !trap_req));

  // R7: clear without switch-OR leaves zero, link kept
  p_test_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(is_test, 2) && $past(instr[7], 2) && !$past(instr[2], 2))
      |-> (ac_out == '0 && link_out == $past(link_in, 2)));

  // R9: no halt in user mode
  p_user_no_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(user_mode, 2)) |-> !halt_req);

  // R9: halt and trap never together
  p_halt_trap_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && trap_req));

  // R10: extension encoding passes through
  p_ext_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(is_ext, 2))
      |-> (ac_out == $past(ac_in, 2) && link_out == $past(link_in, 2) && !skip && !halt_req && !trap_req));

  // R11: other opcodes pass through
  p_other_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && !$past(is_opr, 2))
      |-> (ac_out == $past(ac_in, 2) && link_out == $past(link_in, 2) && !skip && !halt_req && !trap_req));

endmodule

bind opr_exec opr_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .ac_in     (ac_in),
  .link_in   (link_in),
  .user_mode (user_mode),
  .out_valid (out_valid),
  .ac_out    (ac_out),
  .link_out  (link_out),
  .skip      (skip),
  .halt_req  (halt_req),
  .trap_req  (trap_req)
);

// File: tb/tb_opr_exec.sv
module tb_opr_exec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] ac_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] switches = '0;
  logic        user_mode = 1'b0;
  logic        out_valid;
  logic [11:0] ac_out;
  logic        link_out;
  logic        skip;
  logic        halt_req;
  logic        trap_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  opr_exec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .ac_in(ac_in), .link_in(link_in), .switches(switches), .user_mode(user_mode),
    .out_valid(out_valid), .ac_out(ac_out), .link_out(link_out),
    .skip(skip), .halt_req(halt_req), .trap_req(trap_req)
  );

  typedef struct {
    bit          v;
    logic [11:0] ac;
    logic        l;
    logic        sk;
    logic        h;
    logic        t;
    string       tag;
    string       ftag;
  } exp_t;

  exp_t e1, e2;

  function automatic exp_t model(bit v, logic [11:0] i, logic [11:0] a, logic l,
                                 logic [11:0] sw, logic u);
    exp_t e;
    logic c;
    e.v = v; e.sk = 1'b0; e.h = 1'b0; e.t = 1'b0;
    e.tag = "R11"; e.ftag = "R11";
    if (v && i[11:9] == 3'o7) begin
      if (!i[8]) begin
        e.ftag = "R5";
        e.tag  = (i[3:1] != 3'd0) ? "R4" : (i[0] ? "R3" : "R2");
        if (i[7]) a = '0;
        if (i[6]) l = 1'b0;
        if (i[5]) a = ~a;
        if (i[4]) l = ~l;
        {l, a} = {l, a} + {12'd0, i[0]};
        case (i[3:1])
          3'd1: a = {a[5:0], a[11:6]};
          3'd2: {l, a} = {a, l};
          3'd3: {l, a} = {a[10:0], l, a[11]};
          3'd4: {l, a} = {a[0], l, a[11:1]};
          3'd5: {l, a} = {a[1:0], l, a[11:2]};
          default: ;
        endcase
      end else if (!i[0]) begin
        c = (i[6] && a[11]) || (i[5] && a == 12'd0) || (i[4] && l);
        e.sk = (c != i[3]);
        if (i[7]) a = '0;
        if (u) begin
          e.t = i[2] | i[1];
          e.tag = "R9"; e.ftag = "R9";
        end else begin
          if (i[2]) a = a | sw;
          e.h = i[1];
          e.tag = "R7"; e.ftag = i[1] ? "R8" : "R6";
        end
      end else begin
        e.tag = "R10"; e.ftag = "R10";
      end
    end
    e.ac = a; e.l = l;
    return e;
  endfunction

  task automatic check_val(string tag, string what, logic [12:0] act, logic [12:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0o expected %0o", tag, what, act, exp);
    end
  endtask

  task automatic verify(exp_t e);
    check_val("R1", "out_valid", {12'd0, out_valid}, {12'd0, e.v});
    if (e.v) begin
      check_val(e.tag,  "ac",   {1'b0, ac_out}, {1'b0, e.ac});
      check_val(e.tag,  "link", {12'd0, link_out}, {12'd0, e.l});
      check_val(e.ftag, "skip", {12'd0, skip}, {12'd0, e.sk});
      check_val(e.ftag, "halt", {12'd0, halt_req}, {12'd0, e.h});
      check_val(e.ftag, "trap", {12'd0, trap_req}, {12'd0, e.t});
    end else begin
      check_val("R1", "idle flags", {10'd0, skip, halt_req, trap_req}, 13'd0);
    end
  endtask

  // one cycle: check the word offered two cycles ago, then offer a new one
  task automatic step(bit v, logic [11:0] i, logic [11:0] a, logic l,
                      logic [11:0] sw, logic u);
    @(negedge clk);
    verify(e2);
    e2 = e1;
    e1 = model(v, i, a, l, sw, u);
    in_valid = v; instr = i; ac_in = a; link_in = l; switches = sw; user_mode = u;
  endtask

  task automatic idle();
    step(1'b0, 12'd0, 12'd0, 1'b0, 12'd0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    e1 = model(1'b0, '0, '0, 1'b0, '0, 1'b0);
    e2 = e1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_val("R1", "reset out_valid", {12'd0, out_valid}, 13'd0);
    check_val("R1", "reset ac", {1'b0, ac_out}, 13'd0);
    check_val("R1", "reset link/flags", {9'd0, link_out, skip, halt_req, trap_req}, 13'd0);
    rst_n = 1'b1;
    repeat (6) idle();

    // R2 clears and inverts
    step(1, 12'o7300, 12'o1234, 1, 12'o0, 0);
    step(1, 12'o7240, 12'o1234, 0, 12'o0, 0);
    step(1, 12'o7120, 12'o0055, 1, 12'o0, 0);
    // R3 increment and wrap
    step(1, 12'o7001, 12'o7777, 1, 12'o0, 0);
    step(1, 12'o7001, 12'o7777, 0, 12'o0, 0);
    step(1, 12'o7201, 12'o4321, 0, 12'o0, 0);
    step(1, 12'o7041, 12'o0005, 0, 12'o0, 0);
    // R4 shifts
    step(1, 12'o7002, 12'o1234, 1, 12'o0, 0);
    step(1, 12'o7004, 12'o4001, 1, 12'o0, 0);
    step(1, 12'o7006, 12'o6001, 1, 12'o0, 0);
    step(1, 12'o7010, 12'o0003, 1, 12'o0, 0);
    step(1, 12'o7012, 12'o0003, 1, 12'o0, 0);
    step(1, 12'o7014, 12'o5252, 1, 12'o0, 0);
    step(1, 12'o7016, 12'o5252, 1, 12'o0, 0);
    step(1, 12'o7005, 12'o7777, 0, 12'o0, 0);
    // R6 skips
    step(1, 12'o7410, 12'o1111, 0, 12'o0, 0);
    step(1, 12'o7500, 12'o4000, 0, 12'o0, 0);
    step(1, 12'o7440, 12'o0000, 0, 12'o0, 0);
    step(1, 12'o7420, 12'o0001, 1, 12'o0, 0);
    step(1, 12'o7450, 12'o0000, 0, 12'o0, 0);
    step(1, 12'o7640, 12'o0003, 1, 12'o0, 0);
    // R7 clear and switch-OR
    step(1, 12'o7600, 12'o7070, 1, 12'o1111, 0);
    step(1, 12'o7604, 12'o7070, 0, 12'o5555, 0);
    step(1, 12'o7404, 12'o0070, 0, 12'o5500, 0);
    // R8 halt
    step(1, 12'o7402, 12'o0123, 0, 12'o0, 0);
    // R9 user mode
    step(1, 12'o7402, 12'o0123, 0, 12'o7777, 1);
    step(1, 12'o7604, 12'o0123, 0, 12'o7777, 1);
    step(1, 12'o7404, 12'o0123, 1, 12'o7777, 1);
    // R10 / R11 pass-through
    step(1, 12'o7401, 12'o3333, 1, 12'o0, 0);
    step(1, 12'o7621, 12'o3333, 0, 12'o0, 0);
    step(1, 12'o1234, 12'o2222, 1, 12'o0, 0);
    step(1, 12'o6201, 12'o2222, 0, 12'o7777, 1);
    repeat (3) idle();

    // random mix
    void'($urandom(32'd24680));
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] ri, ra, rs;
      logic [3:0]  pick;
      pick = 4'($urandom);
      ri = 12'($urandom);
      if (pick < 4'd13) ri[11:9] = 3'o7;
      ra = 12'($urandom);
      if (pick[1:0] == 2'd0) ra = 12'd0;
      if (pick[1:0] == 2'd1 && pick[3]) ra = 12'o7777;
      rs = 12'($urandom);
      step(($urandom % 5) != 0, ri, ra, 1'($urandom), rs, 1'($urandom));
    end
    repeat (3) idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule